// File: doc/BRIEF.md
# Time-Multiplexed Model Port

This block is the buffer that joins two simulation modules when one physical pipeline stands in for several virtual cores. Each virtual instance puts exactly one token per model cycle into the port. A token carries either a real message or an empty marker. Because of this, model time keeps moving even when no traffic is present. The storage has room for `NUM_INST*LATENCY+1` tokens. At reset it comes up already holding `NUM_INST*LATENCY` empty markers. This lets the consumer start on the first instance while the producer is still a full latency window ahead.

The producer side works like a ready/valid stream in which `full` is the inverse of ready. The producer asserts `push` for one clock to offer a token, and the token is taken only when `full` is low. A `push` while `full` is high is dropped and latches a sticky error. The consumer side mirrors this. `empty` low means a token is valid at the head, and `pop` takes it. A `pop` while `empty` is high is dropped and latches its own sticky error. The port also shows whether its fill is above (`heavy`) or below (`light`) the reset token count, for distributed resynchronization. It reports which virtual instance the next push and the current head belong to.

Top module: `tm_model_port`

## Requirements
- R1: After reset, `empty`, `full`, `heavy`, `light`, `err_overflow` and `err_underflow` are all 0, and `push_inst` and `pop_inst` are both 0.
- R2: The first `NUM_INST*LATENCY` tokens popped after reset are empty markers: `pop_msg` = 0 (0 means no message, 1 means message) and `pop_data` = 0.
- R3: Accepted pushes leave the port in the order they were accepted, with their `push_msg` flag and `push_data` unchanged, behind any tokens already held.
- R4: `full` is 1 exactly when `NUM_INST*LATENCY+1` tokens are held, and `empty` is 1 exactly when none are held.
- R5: `heavy` is 1 exactly when more than `NUM_INST*LATENCY` tokens are held. `light` is 1 exactly when fewer are held.
- R6: An accepted push and an accepted pop in the same clock leave the number of held tokens unchanged.
- R7: A push while `full` is 1 stores nothing and sets `err_overflow`. `err_overflow` stays 1 until reset.
- R8: A pop while `empty` is 1 removes nothing, leaves `pop_inst` unchanged, and sets `err_underflow`. `err_underflow` stays 1 until reset.
- R9: `push_inst` goes up by one, modulo `NUM_INST`, on each accepted push. `pop_inst` does the same on each accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, preloads the port |
| push | input | 1 | Offer one token from the producer |
| push_msg | input | 1 | 1 = message, 0 = no-message marker |
| push_data | input | DATA_W | Message payload |
| full | output | 1 | No room, so a push is dropped |
| pop | input | 1 | Consumer takes the head token |
| pop_msg | output | 1 | Head token kind |
| pop_data | output | DATA_W | Head token payload |
| empty | output | 1 | No token at head |
| push_inst | output | IW | Virtual instance of the next push |
| pop_inst | output | IW | Virtual instance of the head token |
| heavy | output | 1 | Fill above reset count |
| light | output | 1 | Fill below reset count |
| err_overflow | output | 1 | Sticky: push while full |
| err_underflow | output | 1 | Sticky: pop while empty |

## Verification
Directed sequences drain the preload to show that empty markers come first and that the port empties at zero. They fill the one spare slot to reach full and heavy, and they issue illegal pushes and pops. Each illegal access is checked for leaving contents and instance counters alone while raising only its own error flag. A same-clock push and pop at the reset fill separates true occupancy hold from a stray increment or decrement. Random phases change the push and pop rates so that the fill swings between light, balanced and heavy. These phases compare order, payloads and instance tags against a queue model.

// File: rtl/tm_port_pkg.sv
package tm_port_pkg;
  typedef enum logic {
    TOK_NONE = 1'b0,
    TOK_MSG  = 1'b1
  } tok_kind_e;

  function automatic int port_slots(input int n_inst, input int lat);
    return n_inst * lat + 1;
  endfunction

  function automatic int port_preload(input int n_inst, input int lat);
    return n_inst * lat;
  endfunction
endpackage

// File: rtl/tm_port_store.sv
module tm_port_store
  import tm_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 9,
  parameter int INIT   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  tok_kind_e         wr_kind,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output tok_kind_e         rd_kind,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
  localparam logic [PW-1:0] WR_RST = PW'(INIT % DEPTH);

  logic [PW-1:0] wr_ptr, rd_ptr;
  tok_kind_e         kind_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= WR_RST;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        kind_q[i] <= TOK_NONE;
        data_q[i] <= '0;
      end else if (wr_en && (wr_ptr == PW'(i))) begin
        kind_q[i] <= wr_kind;
        data_q[i] <= wr_data;
      end
    end
  end

  assign rd_kind = kind_q[rd_ptr];
  assign rd_data = data_q[rd_ptr];

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr <= LAST) && (rd_ptr <= LAST));
endmodule

// File: rtl/tm_port_level.sv
module tm_port_level #(
  parameter int DEPTH = 9,
  parameter int INIT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output logic push_ok,
  output logic pop_ok,
  output logic full,
  output logic empty,
  output logic heavy,
  output logic light,
  output logic err_over,
  output logic err_under
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] INIT_C  = CW'(INIT);

  logic [CW-1:0] count;

  assign full    = (count == DEPTH_C);
  assign empty   = (count == '0);
  assign heavy   = (count > INIT_C);
  assign light   = (count < INIT_C);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= INIT_C;
      err_over  <= 1'b0;
      err_under <= 1'b0;
    end else begin
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
      if (push && full)  err_over  <= 1'b1;
      if (pop && empty)  err_under <= 1'b1;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  assert_hold_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (count == $past(count)));
  assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && err_over));
  assert_drop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (empty && err_under));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_over |=> err_over);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_under |=> err_under);
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(heavy && light) && !(full && empty));
endmodule

// File: rtl/tm_port_seq.sv
module tm_port_seq #(
  parameter int N_INST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic [((N_INST > 1) ? $clog2(N_INST) : 1)-1:0] idx
);
  localparam int IW = (N_INST > 1) ? $clog2(N_INST) : 1;
  localparam logic [IW-1:0] LAST = IW'(N_INST - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (step) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  assert_inst_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);
  assert_inst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx));
endmodule

// File: rtl/tm_model_port.sv
module tm_model_port
  import tm_port_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_INST = 4,
  parameter int LATENCY  = 2,
  localparam int IW = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_msg,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  input  logic              pop,
  output logic              pop_msg,
  output logic [DATA_W-1:0] pop_data,
  output logic              empty,
  output logic [IW-1:0]     push_inst,
  output logic [IW-1:0]     pop_inst,
  output logic              heavy,
  output logic              light,
  output logic              err_overflow,
  output logic              err_underflow
);
  localparam int DEPTH = port_slots(NUM_INST, LATENCY);
  localparam int INIT  = port_preload(NUM_INST, LATENCY);

  logic      push_ok, pop_ok;
  tok_kind_e head_kind;
  tok_kind_e in_kind;

  assign in_kind = push_msg ? TOK_MSG : TOK_NONE;
  assign pop_msg = (head_kind == TOK_MSG);

  tm_port_level #(.DEPTH(DEPTH), .INIT(INIT)) u_level (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_ok(push_ok), .pop_ok(pop_ok), .full(full), .empty(empty),
    .heavy(heavy), .light(light),
    .err_over(err_overflow), .err_under(err_underflow)
  );

  tm_port_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .INIT(INIT)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_ok), .wr_kind(in_kind), .wr_data(push_data),
    .rd_en(pop_ok), .rd_kind(head_kind), .rd_data(pop_data)
  );

  tm_port_seq #(.N_INST(NUM_INST)) u_wr_seq (
    .clk(clk), .rst_n(rst_n), .step(push_ok), .idx(push_inst)
  );

  tm_port_seq #(.N_INST(NUM_INST)) u_rd_seq (
    .clk(clk), .rst_n(rst_n), .step(pop_ok), .idx(pop_inst)
  );

  assert_preload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pop_msg && (pop_data == '0)));
  assert_tag_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(pop_inst));
endmodule

// File: tb/tb_tm_model_port.sv
module tb_tm_model_port;
  localparam int DW = 8;
  localparam int NI = 4;
  localparam int LT = 2;
  localparam int IW = 2;
  localparam int DEPTH = NI * LT + 1;
  localparam int INIT  = NI * LT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, push_msg = 1'b0, pop = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic full, empty, pop_msg, heavy, light, err_overflow, err_underflow;
  logic [DW-1:0] pop_data;
  logic [IW-1:0] push_inst, pop_inst;

  int total = 0;
  int bad = 0;

  logic          mq_msg [$];
  logic [DW-1:0] mq_dat [$];
  int m_win, m_rin;
  bit m_eo, m_eu;

  always #4 clk = ~clk;

  tm_model_port #(.DATA_W(DW), .NUM_INST(NI), .LATENCY(LT)) dut (
    .clk(clk), .rst_n(rst_n), .push(push), .push_msg(push_msg),
    .push_data(push_data), .full(full), .pop(pop), .pop_msg(pop_msg),
    .pop_data(pop_data), .empty(empty), .push_inst(push_inst),
    .pop_inst(pop_inst), .heavy(heavy), .light(light),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  function automatic int msize();
    return mq_msg.size();
  endfunction

  task automatic check_all(input string ctx);
    chk({ctx, " R4 empty"}, empty, msize() == 0);
    chk({ctx, " R4 full"}, full, msize() == DEPTH);
    chk({ctx, " R5 heavy"}, heavy, msize() > INIT);
    chk({ctx, " R5 light"}, light, msize() < INIT);
    chk({ctx, " R9 push_inst"}, push_inst, m_win);
    chk({ctx, " R9 pop_inst"}, pop_inst, m_rin);
    chk({ctx, " R7 err_overflow"}, err_overflow, m_eo);
    chk({ctx, " R8 err_underflow"}, err_underflow, m_eu);
    if (msize() > 0) begin
      chk({ctx, " R3 pop_msg"}, pop_msg, mq_msg[0]);
      chk({ctx, " R3 pop_data"}, pop_data, mq_dat[0]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push = 0; pop = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mq_msg.delete(); mq_dat.delete();
    for (int i = 0; i < INIT; i++) begin
      mq_msg.push_back(1'b0); mq_dat.push_back('0);
    end
    m_win = 0; m_rin = 0; m_eo = 0; m_eu = 0;
  endtask

  // called at a negedge; applies one clock of stimulus, returns at the next negedge
  task automatic step(input bit p, input bit pm, input logic [DW-1:0] pd, input bit q);
    bit p_ok, q_ok;
    push = p; push_msg = pm; push_data = pd; pop = q;
    p_ok = p && (msize() != DEPTH);
    q_ok = q && (msize() != 0);
    if (p && !p_ok) m_eo = 1;
    if (q && !q_ok) m_eu = 1;
    if (q_ok) begin void'(mq_msg.pop_front()); void'(mq_dat.pop_front()); m_rin = (m_rin + 1) % NI; end
    if (p_ok) begin mq_msg.push_back(pm); mq_dat.push_back(pd); m_win = (m_win + 1) % NI; end
    @(posedge clk);
    @(negedge clk);
    push = 0; pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got 1 exp 0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    do_reset();
    // R1 reset state
    chk("R1 empty", empty, 0); chk("R1 full", full, 0);
    chk("R1 heavy", heavy, 0); chk("R1 light", light, 0);
    chk("R1 err_overflow", err_overflow, 0); chk("R1 err_underflow", err_underflow, 0);
    chk("R1 push_inst", push_inst, 0); chk("R1 pop_inst", pop_inst, 0);

    // R6: push and pop together at reset fill
    step(1, 1, 8'hA5, 1);
    chk("R6 heavy", heavy, 0); chk("R6 light", light, 0);
    check_all("R6");

    // R2: drain the remaining preload, all markers
    do_reset();
    for (int i = 0; i < INIT; i++) begin
      chk("R2 pop_msg", pop_msg, 0);
      chk("R2 pop_data", pop_data, 0);
      step(0, 0, '0, 1);
    end
    chk("R4 empty at zero", empty, 1);
    chk("R5 light when drained", light, 1);
    check_all("R4 drained");
    // R8: pop while empty ignored
    step(0, 0, '0, 1);
    chk("R8 err_underflow", err_underflow, 1);
    chk("R8 pop_inst held", pop_inst, 0);
    chk("R8 still empty", empty, 1);
    chk("R7 overflow untouched", err_overflow, 0);
    check_all("R8");

    // R4/R5/R7: fill the spare slot then push again
    do_reset();
    step(1, 1, 8'h3C, 0);
    chk("R4 full at depth", full, 1);
    chk("R5 heavy above init", heavy, 1);
    step(1, 1, 8'hFF, 0);
    chk("R7 err_overflow", err_overflow, 1);
    chk("R8 underflow untouched", err_underflow, 0);
    chk("R9 push_inst held", push_inst, 1);
    check_all("R7");
    for (int i = 0; i < INIT; i++) step(0, 0, '0, 1);
    chk("R3 pushed msg", pop_msg, 1);
    chk("R3 pushed data", pop_data, 8'h3C);
    step(0, 0, '0, 1);
    chk("R7 dropped push absent", empty, 1);

    // random legal traffic with varying bias
    do_reset();
    for (int ph = 0; ph < 6; ph++) begin
      int pp, qp;
      pp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 20 : 50;
      qp = 100 - pp;
      for (int c = 0; c < 400; c++) begin
        bit p, q;
        p = (($urandom % 100) < pp) && (msize() != DEPTH);
        q = (($urandom % 100) < qp) && (msize() != 0);
        step(p, 1'($urandom), 8'($urandom), q);
        check_all("rand R3");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule